// File: doc/BRIEF.md
# Dual-Protocol Serial Configuration Register Port

This block is a write-only register file that a host fills over one of two serial buses: a two-wire bus with START/STOP framing and per-byte acknowledge, or a three-wire bus made of a serial clock, a data line and an enable strobe. A static select input picks which bus is live. The other bus is held idle, so nothing it carries can change a register. Every implemented register drives a parallel output, and the chip's datapath reads its settings from those outputs.

On the two-wire bus, a write starts with a device address. The top five address bits are fixed and the next two come from strap pins, so four devices can share one bus. Next comes a subaddress byte. Its low nibble selects a register and its bit 4 chooses how the data bytes that follow are handled: either the index steps after each byte, or every data byte needs a new subaddress. A three-wire transfer is a 16-bit frame, an address byte followed by a data byte, committed when the enable strobe drops.

The register file also merges one 9-bit offset value per colour channel. Its low eight bits come from one register, and its MSB is the top bit of the paired coarse-gain register.

Top module: `serial_cfg_regs`

## Requirements
- R1: After reset, registers 0, 2 and 4 hold 8'h7F, registers 1, 3 and 5 hold 8'h20, and every other implemented register holds 8'h00. The acknowledge pull is inactive.
- R2: On the two-wire bus, the block acknowledges an address byte equal to {5'b10011, addr_strap[1], addr_strap[0], 1'b0} by pulling sda_pull high during the ninth clock. Any other address gets no acknowledge, and all bytes up to the next START are ignored.
- R3: An address byte whose matching device bits are followed by a direction bit of 1 gets no acknowledge, and its transfer writes nothing.
- R4: The byte after a matching address is the subaddress. Bits [3:0] give the register index, bit 4 is the mode flag and bits [7:5] are ignored. Every subaddress byte and every data byte is acknowledged.
- R5: With mode flag 0, consecutive data bytes go to the index, then index+1 and so on. The 4-bit index wraps from 15 to 0, and the stream runs until a STOP or a new START.
- R6: With mode flag 1, each data byte writes one register, and the byte after it is read as a new subaddress.
- R7: A data byte addressed to an index at or above NREG (12 by default) is acknowledged on the two-wire bus and then dropped. No register changes.
- R8: After a STOP, clocked bytes without a new START are ignored. A repeated START makes the next byte an address byte again.
- R9: On the three-wire bus, sdi3 is shifted MSB first on each rising sck3 edge while sen3 is high. When sen3 falls after exactly 16 bits, register frame[11:8] takes frame[7:0], and frame[15:12] is ignored.
- R10: A three-wire frame of any length other than 16 bits writes nothing.
- R11: With bus_sel = 0, only the two-wire bus can write. With bus_sel = 1, only the three-wire bus can write, and the two-wire bus gives no acknowledge.
- R12: ofs_word[9c+8:9c] equals {register(2c+1)[7], register(2c)} for each channel c.
- R13: A register holds its value except in the cycle after a write to its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both buses are oversampled in this domain |
| rst_n | input | 1 | Asynchronous active-low reset; loads register defaults |
| bus_sel | input | 1 | Static bus select: 0 two-wire, 1 three-wire |
| addr_strap | input | 2 | Strap levels placed in device address bits [2:1] |
| scl | input | 1 | Two-wire clock |
| sda | input | 1 | Two-wire data line as seen on the pad |
| sda_pull | output | 1 | High to pull the two-wire data line low (acknowledge) |
| sck3 | input | 1 | Three-wire clock |
| sdi3 | input | 1 | Three-wire data |
| sen3 | input | 1 | Three-wire enable, active high |
| regs_flat | output | NREG*8 | Register i on bits [8i+7:8i] |
| ofs_word | output | NCH*9 | Merged 9-bit offset per channel |

## Verification
A wrong subaddress index or mode latch shows up as a misplaced register value one system clock after the acknowledge clock edge of the affected data byte. A broken START, STOP or address decode shows up on sda_pull during the ninth clock of the byte that follows. On the three-wire side, a wrong bit count becomes visible one cycle after sen3 falls, as a write that should have been dropped or a missing one. The bench keeps its own model of all registers and compares the whole file after each scenario, so a stray write to a neighbouring index is caught too.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int DW   = 8;
  localparam int IDXW = 4;

  typedef enum logic [2:0] {TW_IDLE, TW_ADDR, TW_SUB, TW_DATA, TW_SKIP} tw_state_e;

  // Reset value of register idx: offsets mid-scale, coarse gains 32, rest zero.
  function automatic logic [DW-1:0] reg_default(input int idx);
    if (idx < 6) return (idx % 2 == 0) ? 8'h7F : 8'h20;
    return 8'h00;
  endfunction

  // 7-bit device identity on the two-wire bus.
  function automatic logic [6:0] dev_id(input logic [1:0] strap);
    return {5'b10011, strap};
  endfunction

  function automatic logic idx_ok(input logic [IDXW-1:0] idx, input int n);
    return int'(idx) < n;
  endfunction

  // 9-bit offset: MSB from top bit of the coarse register.
  function automatic logic [8:0] join_offset(input logic [DW-1:0] lo, input logic [DW-1:0] hi);
    return {hi[DW-1], lo};
  endfunction
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int           W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/scfg_twowire.sv
module scfg_twowire
  import scfg_pkg::*;
#(
  parameter int NREG = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic [1:0]      strap,
  output logic            ack_drive,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [DW-1:0]   wr_data,
  output logic            ev_byte_done
);
  tw_state_e       st;
  logic            scl_q, sda_q;
  logic [3:0]      bcnt;
  logic            in_ack;
  logic [DW-1:0]   sh;
  logic [IDXW-1:0] idx;
  logic            single;

  logic scl_rise, scl_fall, start_c, stop_c, receiving, addr_hit;

  assign scl_rise     = scl_s & ~scl_q;
  assign scl_fall     = ~scl_s & scl_q;
  assign start_c      = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c       = scl_s & scl_q & ~sda_q & sda_s;
  assign receiving    = (st == TW_ADDR) || (st == TW_SUB) || (st == TW_DATA);
  assign ev_byte_done = scl_fall && (bcnt == 4'd8) && !in_ack && receiving && !clr;
  assign addr_hit     = (sh[7:1] == dev_id(strap)) && !sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TW_IDLE;  scl_q <= 1'b1;  sda_q <= 1'b1;
      bcnt <= '0;  in_ack <= 1'b0;  ack_drive <= 1'b0;
      sh <= '0;  idx <= '0;  single <= 1'b0;
      wr_en <= 1'b0;  wr_idx <= '0;  wr_data <= '0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      wr_en <= 1'b0;
      if (clr || stop_c) begin
        st <= TW_IDLE;  bcnt <= '0;  in_ack <= 1'b0;  ack_drive <= 1'b0;
      end else if (start_c) begin
        st <= TW_ADDR;  bcnt <= '0;  in_ack <= 1'b0;  ack_drive <= 1'b0;
      end else if (ev_byte_done) begin
        unique case (st)
          TW_ADDR: begin
            if (addr_hit) begin
              ack_drive <= 1'b1;  in_ack <= 1'b1;  st <= TW_SUB;
            end else begin
              st <= TW_SKIP;
            end
          end
          TW_SUB: begin
            ack_drive <= 1'b1;  in_ack <= 1'b1;
            idx    <= sh[IDXW-1:0];
            single <= sh[4];
            st     <= TW_DATA;
          end
          TW_DATA: begin
            ack_drive <= 1'b1;  in_ack <= 1'b1;
            wr_en   <= idx_ok(idx, NREG);
            wr_idx  <= idx;
            wr_data <= sh;
            if (single) st <= TW_SUB;
            else        idx <= idx + 1'b1;
          end
          default: ;
        endcase
      end else if (scl_fall && in_ack) begin
        in_ack <= 1'b0;  ack_drive <= 1'b0;  bcnt <= '0;
      end else if (scl_rise && receiving && !in_ack && bcnt < 4'd8) begin
        sh   <= {sh[DW-2:0], sda_s};
        bcnt <= bcnt + 4'd1;
      end
    end
  end
endmodule

// File: rtl/scfg_threewire.sv
module scfg_threewire
  import scfg_pkg::*;
#(
  parameter int NREG = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            sck_s,
  input  logic            sdi_s,
  input  logic            en_s,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [DW-1:0]   wr_data
);
  localparam int FRAME = 2 * DW;
  localparam int SHW   = IDXW + DW;
  localparam int CW    = $clog2(FRAME + 2);
  localparam logic [CW-1:0] FULL = CW'(FRAME);
  localparam logic [CW-1:0] OVER = CW'(FRAME + 1);

  logic          sck_q, en_q;
  logic [CW-1:0] cnt;
  logic [SHW-1:0] sh;
  logic en_rise, en_fall, sck_rise;

  assign en_rise  = en_s & ~en_q;
  assign en_fall  = ~en_s & en_q;
  assign sck_rise = sck_s & ~sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;  en_q <= 1'b0;  cnt <= '0;  sh <= '0;
      wr_en <= 1'b0;  wr_idx <= '0;  wr_data <= '0;
    end else begin
      sck_q <= sck_s;
      en_q  <= en_s;
      wr_en <= 1'b0;
      if (clr || en_rise) begin
        cnt <= '0;
      end else if (en_fall) begin
        if (cnt == FULL) begin
          wr_en   <= idx_ok(sh[SHW-1:DW], NREG);
          wr_idx  <= sh[SHW-1:DW];
          wr_data <= sh[DW-1:0];
        end
        cnt <= '0;
      end else if (en_s && sck_rise) begin
        sh <= {sh[SHW-2:0], sdi_s};
        if (cnt != OVER) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scfg_bank.sv
module scfg_bank
  import scfg_pkg::*;
#(
  parameter int NREG = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [NREG*DW-1:0] q_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 q_flat[g*DW +: DW] <= reg_default(g);
      else if (wr_en && wr_idx == IDXW'(g))       q_flat[g*DW +: DW] <= wr_data;
    end
  end
endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs
  import scfg_pkg::*;
#(
  parameter int NREG = 12,
  parameter int NCH  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic [1:0]         addr_strap,
  input  logic               scl,
  input  logic               sda,
  output logic               sda_pull,
  input  logic               sck3,
  input  logic               sdi3,
  input  logic               sen3,
  output logic [NREG*DW-1:0] regs_flat,
  output logic [NCH*9-1:0]   ofs_word
);
  logic [1:0] tw_sync;
  logic [2:0] w3_sync;

  logic            tw_wr, w3_wr, wr_en, tw_byte_done;
  logic [IDXW-1:0] tw_idx, w3_idx, wr_idx;
  logic [DW-1:0]   tw_data, w3_data, wr_data;

  scfg_sync #(.W(2), .INIT(2'b11)) u_tw_sync (
    .clk(clk), .rst_n(rst_n), .d({scl, sda}), .q(tw_sync));

  scfg_sync #(.W(3), .INIT(3'b000)) u_w3_sync (
    .clk(clk), .rst_n(rst_n), .d({sck3, sdi3, sen3}), .q(w3_sync));

  scfg_twowire #(.NREG(NREG)) u_tw (
    .clk(clk), .rst_n(rst_n), .clr(bus_sel),
    .scl_s(tw_sync[1]), .sda_s(tw_sync[0]), .strap(addr_strap),
    .ack_drive(sda_pull), .wr_en(tw_wr), .wr_idx(tw_idx), .wr_data(tw_data),
    .ev_byte_done(tw_byte_done));

  scfg_threewire #(.NREG(NREG)) u_w3 (
    .clk(clk), .rst_n(rst_n), .clr(~bus_sel),
    .sck_s(w3_sync[2]), .sdi_s(w3_sync[1]), .en_s(w3_sync[0]),
    .wr_en(w3_wr), .wr_idx(w3_idx), .wr_data(w3_data));

  assign wr_en   = bus_sel ? w3_wr   : tw_wr;
  assign wr_idx  = bus_sel ? w3_idx  : tw_idx;
  assign wr_data = bus_sel ? w3_data : tw_data;

  scfg_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .q_flat(regs_flat));

  for (genvar c = 0; c < NCH; c++) begin : g_ofs
    assign ofs_word[c*9 +: 9] = join_offset(regs_flat[(2*c)*DW +: DW],
                                            regs_flat[(2*c+1)*DW +: DW]);
  end
endmodule

// File: rtl/scfg_chk.sv
module scfg_chk #(
  parameter int NREG = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             sda_pull,
  input logic             tw_byte_done,
  input logic             tw_wr,
  input logic             w3_wr,
  input logic             wr_en,
  input logic [3:0]       wr_idx,
  input logic [NREG*8-1:0] regs_flat
);
  // R13: no register moves without a write strobe
  a_r13_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));

  // R2: acknowledge starts only right after a completed byte
  a_r2_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(tw_byte_done));

  // R7: writes reaching the bank target implemented indices only
  a_r7_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NREG));

  // R11: two-wire side silent while three-wire is selected
  a_r11_twowire_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_sel) && bus_sel) |-> (!tw_wr && !sda_pull));

  // R11: at most one engine issues a write
  a_r11_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tw_wr, w3_wr}));
endmodule

bind serial_cfg_regs scfg_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .sda_pull(sda_pull),
  .tw_byte_done(tw_byte_done), .tw_wr(tw_wr), .w3_wr(w3_wr),
  .wr_en(wr_en), .wr_idx(wr_idx), .regs_flat(regs_flat));

// File: tb/test_serial_cfg_regs.sv
`timescale 1ns/1ps
module test_serial_cfg_regs;
  localparam int NREG = 12;
  localparam int NCH  = 3;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0;
  logic [1:0] addr_strap = 2'b10;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sck3 = 1'b0, sdi3 = 1'b0, sen3 = 1'b0;
  logic sda_pull, sda_line;
  logic [NREG*8-1:0] regs_flat;
  logic [NCH*9-1:0]  ofs_word;

  int n_checks = 0;
  int n_err = 0;
  logic [7:0] exp_reg [NREG];

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  serial_cfg_regs #(.NREG(NREG), .NCH(NCH)) i_serial_cfg_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .addr_strap(addr_strap),
    .scl(scl), .sda(sda_line), .sda_pull(sda_pull),
    .sck3(sck3), .sdi3(sdi3), .sen3(sen3),
    .regs_flat(regs_flat), .ofs_word(ofs_word));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NREG; i++)
      check(req, $sformatf("reg%0d", i), 32'(regs_flat[i*8 +: 8]), 32'(exp_reg[i]));
  endtask

  task automatic check_ofs(input string req);
    for (int c = 0; c < NCH; c++)
      check(req, $sformatf("ofs%0d", c), 32'(ofs_word[c*9 +: 9]),
            32'({exp_reg[2*c+1][7], exp_reg[2*c]}));
  endtask

  task automatic tw_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic tw_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic tw_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1;   tick(Q);
      scl = 1'b0;   tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q/2);
    ack = ~sda_line;
    tick(Q/2);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic w3_frame(input int nbits, input logic [16:0] v);
    sen3 = 1'b1; tick(Q);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi3 = v[i]; tick(Q);
      sck3 = 1'b1; tick(Q);
      sck3 = 1'b0;
    end
    tick(Q);
    sen3 = 1'b0; tick(Q);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) exp_reg[i] = (i < 6) ? ((i % 2 == 0) ? 8'h7F : 8'h20) : 8'h00;
    check_all("R1");
    check_ofs("R12");
    check("R1", "sda_pull", 32'(sda_pull), 32'd0);
  endtask

  task automatic t_stream();
    logic a;
    tw_start();
    tw_byte(8'h9C, a); check("R2", "ack addr", 32'(a), 32'd1);
    tw_byte(8'h06, a); check("R4", "ack sub", 32'(a), 32'd1);
    tw_byte(8'hA1, a); check("R4", "ack data", 32'(a), 32'd1);
    tw_byte(8'hA2, a);
    tw_stop(); tick(4);
    exp_reg[6] = 8'hA1; exp_reg[7] = 8'hA2;
    check_all("R5");
  endtask

  task automatic t_bad_addr();
    logic a;
    tw_start();
    tw_byte(8'h98, a); check("R2", "nack foreign addr", 32'(a), 32'd0);
    tw_byte(8'h07, a); check("R2", "skip sub", 32'(a), 32'd0);
    tw_byte(8'h55, a);
    tw_stop(); tick(4);
    check_all("R2");
    tw_start();
    tw_byte(8'h9D, a); check("R3", "nack read dir", 32'(a), 32'd0);
    tw_byte(8'h07, a);
    tw_byte(8'h66, a);
    tw_stop(); tick(4);
    check_all("R3");
  endtask

  task automatic t_wrap();
    logic a;
    tw_start();
    tw_byte(8'h9C, a);
    tw_byte(8'h0F, a);
    tw_byte(8'h11, a); check("R7", "ack unimpl", 32'(a), 32'd1);
    tw_byte(8'h22, a);
    tw_byte(8'h33, a);
    tw_stop(); tick(4);
    exp_reg[0] = 8'h22; exp_reg[1] = 8'h33;
    check_all("R5");
    check_ofs("R12");
  endtask

  task automatic t_single();
    logic a;
    tw_start();
    tw_byte(8'h9C, a);
    tw_byte(8'hF2, a); check("R4", "ack sub mode1", 32'(a), 32'd1);
    tw_byte(8'h44, a);
    tw_byte(8'h13, a); check("R6", "ack second sub", 32'(a), 32'd1);
    tw_byte(8'hD5, a);
    tw_stop(); tick(4);
    exp_reg[2] = 8'h44; exp_reg[3] = 8'hD5;
    check_all("R6");
    check_ofs("R12");
  endtask

  task automatic t_framing();
    logic a;
    scl = 1'b0; tick(Q);
    tw_byte(8'h9C, a); check("R8", "no ack without start", 32'(a), 32'd0);
    tw_byte(8'h08, a);
    tw_byte(8'h66, a);
    check_all("R8");
    tw_start();
    tw_byte(8'h9C, a);
    tw_byte(8'h08, a);
    tw_byte(8'h77, a);
    tw_start();
    tw_byte(8'h9C, a); check("R8", "ack after repeated start", 32'(a), 32'd1);
    tw_byte(8'h09, a);
    tw_byte(8'h88, a);
    tw_stop(); tick(4);
    exp_reg[8] = 8'h77; exp_reg[9] = 8'h88;
    check_all("R8");
  endtask

  task automatic t_three();
    logic a;
    bus_sel = 1'b1; tick(4);
    w3_frame(16, 17'h0A53C); tick(4);
    exp_reg[5] = 8'h3C;
    check_all("R9");
    check_ofs("R12");
    w3_frame(15, 17'h005FF); tick(4);
    check_all("R10");
    w3_frame(17, 17'h005FF); tick(4);
    check_all("R10");
    w3_frame(16, 17'h00B99); tick(4);
    exp_reg[11] = 8'h99;
    w3_frame(16, 17'h00E12); tick(4);
    check_all("R9");
    tw_start();
    tw_byte(8'h9C, a); check("R11", "no ack in three-wire mode", 32'(a), 32'd0);
    tw_byte(8'h00, a);
    tw_byte(8'h5A, a);
    tw_stop(); tick(4);
    check_all("R11");
    bus_sel = 1'b0; tick(4);
    w3_frame(16, 17'h00001); tick(4);
    check_all("R11");
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin : main
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_stream();
    t_bad_addr();
    t_wrap();
    t_single();
    t_framing();
    t_three();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule